// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Flash Master

This block is an SPI master for serial flash and similar command-driven devices. A host reaches it through a simple 32-bit register bus. Software first loads a command word and a 32-byte data buffer. It then programs how many bits each phase carries and writes a start bit. The engine runs up to three phases in a fixed order. The command phase shifts out bits of the command word. The transmit phase shifts out bits of the data buffer. The receive phase samples MISO back into the data buffer. While the engine works, the status bit reads as busy.

Only SPI mode 0 is produced: SCK idles low and data is sampled on the rising edge. The SCK period is a programmable number of system clocks. The bit order inside each byte can be flipped to LSB-first. Two chip-select outputs follow their enable bits directly, so software can keep a device selected across several starts.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, the busy bit, SCK and MOSI are low, both chip selects are high, and the control, command, config, count and chip-select registers read zero.
- R2: A write of 1 to bit 8 at offset 0x00 starts a transfer. Bit 16 of offset 0x00 reads 1 from the next cycle on. Busy stays high for exactly total_bits × (div_sel + 2) system cycles. Here div_sel is bits 27:16 at offset 0x28, and total_bits is the sum of the clamped phase counts.
- R3: A start write while busy is ignored: the transfer length and the bit stream do not change.
- R4: When all three counts are zero, a start causes no busy cycle and no SCK edge.
- R5: Command phase. The count is bits 29:24 at offset 0x2c. The command word is at offset 0x04 and is sent most-significant byte first. Within each byte, bit 3 at offset 0x28 picks the bit order: 0 sends bit 7 first, 1 sends bit 0 first.
- R6: Transmit phase. The count is bits 8:0 at offset 0x2c. Buffer bytes are sent starting at word 0 (offset 0x08), byte 0 first, then upward through the word and on to the next word. The bit order inside each byte follows the same select as R5.
- R7: Receive phase. The count is bits 20:12 at offset 0x2c. MISO is sampled while SCK is high after each rising edge. The received bits are stored with the same byte and bit mapping as R6, starting at word 0. Buffer bits beyond the count keep their old value.
- R8: SCK stays low whenever the block is not busy. MOSI is low outside the command and transmit phases.
- R9: Chip-select output i is low exactly when bit i at offset 0x38 is set, independent of transfer activity.
- R10: A command count above 32 acts as 32. A transmit or receive count above 256 acts as 256.
- R11: The command word, data words (offset 0x08 + 4·i), config, count and chip-select registers read back as written when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| sck_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 2 | Chip selects, active low |

## Verification
The assertions assume that the host does not rewrite the buffer, the command word or the config register while a transfer runs. They also assume MISO changes only while SCK is low, as a mode 0 device behaves. The bench keeps to both rules. It programs every register before the start and waits for busy to fall before any access other than the deliberate duplicate start. Its device model changes MISO only on falling SCK edges. Random transfers draw the divider, the bit order and the three counts from a fixed seed. Directed cases cover zero counts, over-range counts, a full 256-bit receive and a start issued mid-transfer.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int BUF_WORDS   = 8;
  localparam int BUF_BITS    = BUF_WORDS * 32;
  localparam int CMD_MAX     = 32;
  localparam int CMD_CNT_W   = 6;
  localparam int DAT_CNT_W   = $clog2(BUF_BITS + 1);
  localparam int IDX_W       = $clog2(CMD_MAX + 2 * BUF_BITS + 1);

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_BUF0 = 8'h08;
  localparam logic [7:0] OFF_CFG  = 8'h28;
  localparam logic [7:0] OFF_CNT  = 8'h2c;
  localparam logic [7:0] OFF_CS   = 8'h38;

  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;
  localparam int LSB_BIT   = 3;
  localparam int DIV_LSB   = 16;
  localparam int CMD_CNT_LSB = 24;
  localparam int RX_CNT_LSB  = 12;

  typedef enum logic [1:0] {PH_CMD, PH_TX, PH_RX} phase_e;

  // command word: most-significant byte first
  function automatic logic [4:0] cmd_bit_pos(logic [4:0] k, logic lsb);
    return {~k[4:3], lsb ? k[2:0] : ~k[2:0]};
  endfunction

  // buffer: low byte first
  function automatic logic [7:0] buf_bit_pos(logic [7:0] k, logic lsb);
    return {k[7:3], lsb ? k[2:0] : ~k[2:0]};
  endfunction
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             bit_end_o
);
  localparam int NW = DIV_W + 1;

  logic [NW-1:0] cnt_q, per, lo_len;

  assign per    = {1'b0, div_sel_i} + NW'(2);
  assign lo_len = per - (per >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q == per - 1)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign sck_o     = run_i && (cnt_q >= lo_len);
  assign rise_o    = run_i && (cnt_q == lo_len);
  assign bit_end_o = run_i && (cnt_q == per - 1);
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_buf_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CMD_CNT_W-1:0] cmd_cnt_i,
  input  logic [DAT_CNT_W-1:0] tx_cnt_i,
  input  logic [DAT_CNT_W-1:0] rx_cnt_i,
  input  logic                 lsb_i,
  input  logic [DIV_W-1:0]     div_sel_i,
  input  logic [31:0]          cmd_word_i,
  input  logic [BUF_BITS-1:0]  buf_i,
  input  logic                 bit_end_i,
  input  logic                 rise_i,
  input  logic                 miso_i,
  output logic                 busy_o,
  output logic [DIV_W-1:0]     div_o,
  output logic                 mosi_o,
  output logic                 rx_we_o,
  output logic [7:0]           rx_pos_o,
  output logic                 rx_bit_o
);
  logic [CMD_CNT_W-1:0] cmd_c;
  logic [DAT_CNT_W-1:0] tx_c, rx_c;
  logic [IDX_W-1:0]     total, idx_q, cmd_end_q, tx_end_q, tot_q, tx_off, rx_off;
  logic                 busy_q, lsb_q, accept;
  logic [DIV_W-1:0]     div_q;
  phase_e               phase;

  assign cmd_c = (cmd_cnt_i > CMD_CNT_W'(CMD_MAX)) ? CMD_CNT_W'(CMD_MAX) : cmd_cnt_i;
  assign tx_c  = (tx_cnt_i > DAT_CNT_W'(BUF_BITS)) ? DAT_CNT_W'(BUF_BITS) : tx_cnt_i;
  assign rx_c  = (rx_cnt_i > DAT_CNT_W'(BUF_BITS)) ? DAT_CNT_W'(BUF_BITS) : rx_cnt_i;
  assign total = IDX_W'(cmd_c) + IDX_W'(tx_c) + IDX_W'(rx_c);
  assign accept = start_i && !busy_q && (total != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      cmd_end_q <= '0;
      tx_end_q  <= '0;
      tot_q     <= '0;
      lsb_q     <= 1'b0;
      div_q     <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      idx_q     <= '0;
      cmd_end_q <= IDX_W'(cmd_c);
      tx_end_q  <= IDX_W'(cmd_c) + IDX_W'(tx_c);
      tot_q     <= total;
      lsb_q     <= lsb_i;
      div_q     <= div_sel_i;
    end else if (busy_q && bit_end_i) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == tot_q - 1'b1) busy_q <= 1'b0;
    end
  end

  always_comb begin
    if (idx_q < cmd_end_q)     phase = PH_CMD;
    else if (idx_q < tx_end_q) phase = PH_TX;
    else                       phase = PH_RX;
  end

  assign tx_off = idx_q - cmd_end_q;
  assign rx_off = idx_q - tx_end_q;

  always_comb begin
    unique case (phase)
      PH_CMD:  mosi_o = busy_q && cmd_word_i[cmd_bit_pos(idx_q[4:0], lsb_q)];
      PH_TX:   mosi_o = busy_q && buf_i[buf_bit_pos(tx_off[7:0], lsb_q)];
      default: mosi_o = 1'b0;
    endcase
  end

  assign rx_we_o  = busy_q && (phase == PH_RX) && rise_i;
  assign rx_pos_o = buf_bit_pos(rx_off[7:0], lsb_q);
  assign rx_bit_o = miso_i;
  assign busy_o   = busy_q;
  assign div_o    = div_q;

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i)); // R2
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q < tot_q)); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !bit_end_i) |=> busy_q); // R3
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && (total == '0)) |=> !busy_q); // R4
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int CS_NUM = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_NUM-1:0] cs_no
);
  logic [31:0]         cmd_q, cfg_q, cnt_q;
  logic [31:0]         buf_q [BUF_WORDS];
  logic [CS_NUM-1:0]   cs_q;
  logic [BUF_BITS-1:0] buf_flat;
  logic                wr, start, busy, rise, bit_end, rx_we, rx_bit;
  logic [7:0]          rx_pos;
  logic [DIV_W-1:0]    div_run;

  assign wr    = req_i && we_i;
  assign start = wr && (addr_i == OFF_CTRL) && wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      cfg_q <= '0;
      cnt_q <= '0;
      cs_q  <= '0;
    end else if (wr) begin
      if (addr_i == OFF_CMD) cmd_q <= wdata_i;
      if (addr_i == OFF_CFG) cfg_q <= wdata_i;
      if (addr_i == OFF_CNT) cnt_q <= wdata_i;
      if (addr_i == OFF_CS)  cs_q  <= wdata_i[CS_NUM-1:0];
    end
  end

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        buf_q[w] <= '0;
      else if (rx_we && (rx_pos[7:5] == 3'(w)))
        buf_q[w][rx_pos[4:0]] <= rx_bit;
      else if (wr && (addr_i == OFF_BUF0 + 8'(4 * w)))
        buf_q[w] <= wdata_i;
    end
    assign buf_flat[w*32 +: 32] = buf_q[w];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: rdata_o[BUSY_BIT] = busy;
      OFF_CMD:  rdata_o = cmd_q;
      OFF_CFG:  rdata_o = cfg_q;
      OFF_CNT:  rdata_o = cnt_q;
      OFF_CS:   rdata_o[CS_NUM-1:0] = cs_q;
      default: begin
        for (int w = 0; w < BUF_WORDS; w++)
          if (addr_i == OFF_BUF0 + 8'(4 * w)) rdata_o = buf_q[w];
      end
    endcase
  end

  spi_xfer_seq #(.DIV_W(DIV_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cmd_cnt_i  (cnt_q[CMD_CNT_LSB +: CMD_CNT_W]),
    .tx_cnt_i   (cnt_q[0 +: DAT_CNT_W]),
    .rx_cnt_i   (cnt_q[RX_CNT_LSB +: DAT_CNT_W]),
    .lsb_i      (cfg_q[LSB_BIT]),
    .div_sel_i  (cfg_q[DIV_LSB +: DIV_W]),
    .cmd_word_i (cmd_q),
    .buf_i      (buf_flat),
    .bit_end_i  (bit_end),
    .rise_i     (rise),
    .miso_i     (miso_i),
    .busy_o     (busy),
    .div_o      (div_run),
    .mosi_o     (mosi_o),
    .rx_we_o    (rx_we),
    .rx_pos_o   (rx_pos),
    .rx_bit_o   (rx_bit)
  );

  spi_sck_gen #(.DIV_W(DIV_W)) i_sck (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .div_sel_i (div_run),
    .sck_o     (sck_o),
    .rise_o    (rise),
    .bit_end_o (bit_end)
  );

  assign cs_no = ~cs_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o); // R8
  AST_RX_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we |-> sck_o); // R7
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mosi_o); // R8
endmodule

// File: tb/test_spi_buf_master.sv
module test_spi_buf_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi, miso = 1'b0;
  logic [1:0]  cs_n;

  int n_chk = 0, n_bad = 0;

  spi_buf_master i_spi_buf_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  always #10 clk = ~clk;

  // device model: captures MOSI on rising SCK, shifts MISO on falling SCK
  logic slv_clr = 1'b0;
  logic pat [600];
  logic cap [600];
  int   edges = 0;
  always @(posedge sck, negedge sck, posedge slv_clr) begin
    if (slv_clr) begin
      edges = 0;
      miso  = pat[0];
    end else if (sck) begin
      if (edges < 600) cap[edges] = mosi;
      edges++;
    end else begin
      miso = (edges < 600) ? pat[edges] : 1'b0;
    end
  end

  logic [31:0] mbuf [8];
  logic [31:0] mcmd;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic exp_cmd_bit(int k, logic lsb);
    int by = 3 - k / 8;
    int bi = lsb ? k % 8 : 7 - k % 8;
    return mcmd[by*8 + bi];
  endfunction

  function automatic int buf_pos(int k, logic lsb);
    return (k / 8) * 8 + (lsb ? k % 8 : 7 - k % 8);
  endfunction

  task automatic run_txn(input int cmd_raw, input int tx_raw, input int rx_raw,
                         input logic lsb, input int div, input bit dup);
    int cc, tc, rc, tot, cyc, bad, first, pos;
    logic expb;
    logic [31:0] d;
    cc = cmd_raw > 32 ? 32 : cmd_raw;
    tc = tx_raw > 256 ? 256 : tx_raw;
    rc = rx_raw > 256 ? 256 : rx_raw;
    tot = cc + tc + rc;
    mcmd = $urandom;
    for (int w = 0; w < 8; w++) mbuf[w] = $urandom;
    for (int i = 0; i < 600; i++) pat[i] = 1'($urandom);
    bus_wr(8'h28, (32'(div) << 16) | (32'(lsb) << 3));
    bus_wr(8'h04, mcmd);
    for (int w = 0; w < 8; w++) bus_wr(8'h08 + 8'(4*w), mbuf[w]);
    bus_wr(8'h2c, (32'(cmd_raw) << 24) | (32'(rx_raw) << 12) | 32'(tx_raw));
    @(negedge clk); slv_clr = 1'b1; #1 slv_clr = 1'b0;
    bus_wr(8'h00, 32'h100);
    cyc = 0;
    while (i_spi_buf_master.busy === 1'b1 || rdata_busy()) begin
      if (cyc > 20000) break;
      cyc++;
      if (dup && cyc == 3) begin
        req = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'h100;
      end else begin
        req = 1'b0; we = 1'b0; addr = 8'h00;
      end
      @(negedge clk);
    end
    chk(cyc <= 20000, "watchdog", cyc, tot*(div+2));
    chk(cyc == tot*(div+2), dup ? "R3 busy length with duplicate start" :
        (tot == 0 ? "R4 no busy on zero counts" : "R2 busy length"), cyc, tot*(div+2));
    chk(edges == tot, tot == 0 ? "R4 SCK edges" : (cmd_raw > 32 || tx_raw > 256 ? "R10 edge count" : "R5/R6 edge count"), edges, tot);
    bad = 0; first = -1;
    for (int k = 0; k < cc + tc; k++) begin
      if (k < cc) expb = exp_cmd_bit(k, lsb);
      else        expb = mbuf[buf_pos(k - cc, lsb) / 32][buf_pos(k - cc, lsb) % 32];
      if (k < 600 && cap[k] !== expb) begin bad++; if (first < 0) first = k; end
    end
    chk(bad == 0, cc > 0 ? "R5 command bits" : "R6 data bits", first, -1);
    for (int j = 0; j < rc; j++) begin
      pos = buf_pos(j, lsb);
      mbuf[pos / 32][pos % 32] = pat[cc + tc + j];
    end
    for (int w = 0; w < 8; w++) begin
      bus_rd(8'h08 + 8'(4*w), d);
      chk(d == mbuf[w], "R7 receive buffer", d, mbuf[w]);
    end
    chk(sck == 1'b0 && mosi == 1'b0, "R8 idle lines", {sck, mosi}, 0);
  endtask

  function automatic bit rdata_busy();
    return (addr == 8'h00) && rdata[16];
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 600; i++) begin pat[i] = 1'b0; cap[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(sck == 0 && mosi == 0, "R1 lines", {sck, mosi}, 0);
    chk(cs_n == 2'b11, "R1 chip selects", cs_n, 3);
    bus_rd(8'h00, d); chk(d == 0, "R1 control", d, 0);
    bus_rd(8'h04, d); chk(d == 0, "R1 command", d, 0);
    bus_rd(8'h28, d); chk(d == 0, "R1 config", d, 0);
    bus_rd(8'h2c, d); chk(d == 0, "R1 count", d, 0);
    bus_rd(8'h38, d); chk(d == 0, "R1 cs reg", d, 0);

    // R9 chip selects
    bus_wr(8'h38, 32'h1); @(negedge clk); chk(cs_n == 2'b10, "R9 cs0", cs_n, 2);
    bus_wr(8'h38, 32'h2); @(negedge clk); chk(cs_n == 2'b01, "R9 cs1", cs_n, 1);
    bus_rd(8'h38, d); chk(d == 32'h2, "R11 cs readback", d, 2);

    // R11 readback
    bus_wr(8'h28, 32'hA5A5_0F0F); bus_rd(8'h28, d); chk(d == 32'hA5A5_0F0F, "R11 config", d, 32'hA5A5_0F0F);
    bus_wr(8'h04, 32'h1234_5678); bus_rd(8'h04, d); chk(d == 32'h1234_5678, "R11 command", d, 32'h1234_5678);
    bus_wr(8'h18, 32'hCAFE_F00D); bus_rd(8'h18, d); chk(d == 32'hCAFE_F00D, "R11 data word 4", d, 32'hCAFE_F00D);
    bus_wr(8'h2c, 32'h2010_2030); bus_rd(8'h2c, d); chk(d == 32'h2010_2030, "R11 count", d, 32'h2010_2030);

    // directed
    run_txn(0, 0, 0, 1'b0, 0, 1'b0);      // R4
    run_txn(8, 0, 0, 1'b0, 0, 1'b0);      // R5 msb
    run_txn(32, 0, 0, 1'b1, 1, 1'b0);     // R5 lsb
    run_txn(0, 40, 0, 1'b0, 2, 1'b0);     // R6
    run_txn(0, 0, 256, 1'b1, 0, 1'b0);    // R7 full
    run_txn(8, 24, 13, 1'b0, 3, 1'b0);    // R7 partial
    run_txn(40, 300, 0, 1'b0, 0, 1'b0);   // R10
    run_txn(16, 16, 8, 1'b1, 2, 1'b1);    // R3
    chk(cs_n == 2'b01, "R9 cs held across transfers", cs_n, 1);

    // random
    for (int t = 0; t < 16; t++)
      run_txn(int'($urandom_range(0, 32)), int'($urandom_range(0, 96)),
              int'($urandom_range(0, 96)), 1'($urandom), int'($urandom_range(0, 3)), 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3_900_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule